// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog counter for a processor subsystem. Software programs a time-out value through a small register bus and must restart the counter before it runs down. When the count expires, the block sends a one-cycle reset request to an external reset controller. It also latches an overflow flag, which drives an interrupt line when that interrupt is enabled.

The time-out register is write-protected. A fixed 32-bit key must be written to it before it accepts a new value, and every value it accepts locks it again. Loading a value also restarts the count. A debug register takes the key with bit 0 set. That write turns expiry into an interrupt-only event until the next system reset. A pause-enable bit makes the counter hold while the processor reports a debug halt.

The bus is a single-cycle write strobe with address and data. Reads are combinational from the address. The reset controller and the bus fabric are outside this block.

Top module: `keyed_watchdog`

## Requirements
- R1: A read at offset 0x038 always returns 0x251D8950, the key.
- R2: While locked, writing the key to the time-out register (offset 0x03C) unlocks it and leaves the stored time-out value unchanged. The stored value reads back at 0x03C.
- R3: While locked, a write of any non-key value to 0x03C is ignored. The stored time-out and the running count are unchanged.
- R4: While unlocked, a non-key write to 0x03C stores the value, loads it into the count and relocks the register. A key write while unlocked is not stored and leaves the register unlocked.
- R5: After the count is loaded with N, expiry occurs N+1 cycles later. The count then reloads from the stored time-out, so expiries repeat every N+1 cycles. The live count reads at offset 0x010.
- R6: With reset generation enabled, each expiry produces `rst_req` high for exactly one cycle, for N of at least 1.
- R7: Writing 0x251D8951 to the debug register (offset 0x040) stops `rst_req` from ever being asserted until a system reset. Bit 0 of 0x040 reads 1 once this has happened. Any other value written there has no effect.
- R8: Every expiry sets the overflow pending flag (bit 0 at offset 0x00C). `irq` equals pending AND the enable bit (bit 0 at offset 0x004).
- R9: Any write to offset 0x008 clears the pending flag. An expiry in the same cycle takes priority and leaves the flag set.
- R10: While control bit 0 (offset 0x000) is set and `cpu_halted` is high, the count holds its value.
- R11: After reset the register is locked, time-out and count equal RESET_TMO, and pending, enable, pause and the debug disable are all 0. `rst_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | ADDR_W | Byte offset of the register accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| cpu_halted | input | 1 | Processor is in debug halt |
| rst_req | output | 1 | One-cycle reset request to the reset controller |
| irq | output | 1 | Overflow interrupt |

## Verification
The bench times expiry against N+1 cycles and also checks the next period. A counter that is off by one, or that fails to reload, would pulse a cycle early or stop after the first expiry. Lock handling is probed with non-key writes while locked and a repeated key while unlocked. A weak lock would take the stray value or store the key as a time-out. The bench lands an interrupt clear on the same edge as an expiry, which exposes a clear that wrongly wins over the new overflow. It also writes several debug values before and after the disable key. A decoder that ignores bit 0, or a disable that can be undone, would let `rst_req` through or drop the disable bit.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int ADDR_W = 8,
  parameter logic [31:0] RESET_TMO = 32'h0000FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              cpu_halted,
  output logic              rst_req,
  output logic              irq
);
  localparam logic [31:0] KEY = 32'h251D8950;
  localparam logic [31:0] DBG_KEY = KEY ^ 32'h1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_DBG  = ADDR_W'(8'h40);

  logic [31:0] tmo_q, cnt_q;
  logic unlocked_q, rst_dis_q, pause_en_q, ien_q, pend_q, rst_req_q;

  logic wr_tmo, is_key, tmo_load, running, expire, clr_hit;

  assign wr_tmo   = wr_en && (addr == A_TMO);
  assign is_key   = (wr_data == KEY);
  assign tmo_load = wr_tmo && unlocked_q && !is_key;
  assign running  = !(pause_en_q && cpu_halted);
  assign expire   = running && (cnt_q == 32'd0) && !tmo_load;
  assign clr_hit  = wr_en && (addr == A_ICLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q      <= RESET_TMO;
      unlocked_q <= 1'b0;
    end else if (wr_tmo) begin
      if (!unlocked_q) begin
        if (is_key) unlocked_q <= 1'b1;
      end else if (!is_key) begin
        tmo_q      <= wr_data;
        unlocked_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= RESET_TMO;
    else if (tmo_load) cnt_q <= wr_data;
    else if (expire)   cnt_q <= tmo_q;
    else if (running)  cnt_q <= cnt_q - 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_dis_q  <= 1'b0;
      pause_en_q <= 1'b0;
      ien_q      <= 1'b0;
      pend_q     <= 1'b0;
      rst_req_q  <= 1'b0;
    end else begin
      rst_req_q <= expire && !rst_dis_q;
      if (wr_en && addr == A_DBG && wr_data == DBG_KEY) rst_dis_q <= 1'b1;
      if (wr_en && addr == A_CTRL) pause_en_q <= wr_data[0];
      if (wr_en && addr == A_IEN)  ien_q <= wr_data[0];
      if (expire)       pend_q <= 1'b1;
      else if (clr_hit) pend_q <= 1'b0;
    end
  end

  assign rst_req = rst_req_q;
  assign irq     = pend_q && ien_q;

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {31'd0, pause_en_q};
      A_IEN:   rd_data = {31'd0, ien_q};
      A_PEND:  rd_data = {31'd0, pend_q};
      A_CNT:   rd_data = cnt_q;
      A_KEY:   rd_data = KEY;
      A_TMO:   rd_data = tmo_q;
      A_DBG:   rd_data = {31'd0, rst_dis_q};
      default: rd_data = 32'd0;
    endcase
  end

  assert_locked_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TMO && !unlocked_q && wr_data != KEY) |=> $stable(tmo_q));

  assert_load_relocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TMO && unlocked_q && wr_data != KEY)
      |=> (!unlocked_q && tmo_q == $past(wr_data) && cnt_q == $past(wr_data)));

  assert_key_unlocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_TMO && wr_data == KEY) |=> (unlocked_q && $stable(tmo_q)));

  assert_no_reset_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(rst_dis_q));

  assert_disable_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dis_q |=> rst_dis_q);

  assert_pause_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en_q && cpu_halted && !(wr_en && addr == A_TMO)) |=> $stable(cnt_q));

  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && cnt_q != 32'd0) |=> !pend_q);

  assert_irq_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q && ien_q));
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam logic [31:0] KEY = 32'h251D8950;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cpu_halted = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic rst_req, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cpu_halted(cpu_halted), .rst_req(rst_req), .irq(irq)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic load(input logic [31:0] n);
    wr(8'h3C, KEY);
    wr(8'h3C, n);
  endtask

  task automatic t_reset_R11();
    logic [31:0] v;
    rd(8'h3C, v); check(v == 32'hFFFF, "R11 timeout", v, 32'hFFFF);
    rd(8'h10, v); check(v == 32'hFFFF, "R11 count", v, 32'hFFFF);
    rd(8'h40, v); check(v == 0, "R11 debug", v, 0);
    rd(8'h0C, v); check(v == 0, "R11 pending", v, 0);
    check(rst_req == 0 && irq == 0, "R11 outputs", {rst_req, irq}, 0);
  endtask

  task automatic t_key_R1();
    logic [31:0] v;
    rd(8'h38, v); check(v == KEY, "R1 key read", v, KEY);
  endtask

  task automatic t_lock_R2_R3_R4();
    logic [31:0] v;
    wr(8'h3C, 32'd5);
    rd(8'h3C, v); check(v == 32'hFFFF, "R3 locked write ignored", v, 32'hFFFF);
    wr(8'h3C, KEY);
    rd(8'h3C, v); check(v == 32'hFFFF, "R2 key keeps value", v, 32'hFFFF);
    wr(8'h3C, KEY);
    rd(8'h3C, v); check(v == 32'hFFFF, "R4 key not stored", v, 32'hFFFF);
    wr(8'h3C, 32'd500);
    rd(8'h3C, v); check(v == 32'd500, "R4 load stored", v, 500);
    rd(8'h10, v); check(v == 32'd500, "R4 count loaded", v, 500);
    wr(8'h3C, 32'd7);
    rd(8'h3C, v); check(v == 32'd500, "R4 relocked", v, 500);
  endtask

  task automatic t_period_R5_R6();
    logic [31:0] v;
    load(32'd10);
    for (int i = 1; i <= 22; i++) begin
      @(negedge clk);
      if (i == 11 || i == 22) check(rst_req == 1, "R5 expiry at N+1", rst_req, 1);
      else check(rst_req == 0, "R6 single pulse", rst_req, 0);
      if (i == 12) begin
        rd(8'h10, v); check(v == 32'd9, "R5 reload", v, 9);
      end
    end
  endtask

  task automatic t_irq_R8_R9();
    logic [31:0] v;
    wr(8'h04, 32'd0);
    load(32'd1000);
    wr(8'h08, 32'd0);
    load(32'd3);
    repeat (4) @(negedge clk);
    rd(8'h0C, v); check(v == 1, "R8 pending set", v, 1);
    check(irq == 0, "R8 irq masked", irq, 0);
    load(32'd1000);
    wr(8'h04, 32'd1);
    check(irq == 1, "R8 irq enabled", irq, 1);
    wr(8'h08, 32'd0);
    check(irq == 0, "R9 clear", irq, 0);
    load(32'd4);
    repeat (4) @(negedge clk);
    wr(8'h08, 32'd0);
    check(irq == 1, "R9 expiry beats clear", irq, 1);
    load(32'd1000);
    wr(8'h08, 32'd0);
    wr(8'h04, 32'd0);
  endtask

  task automatic t_pause_R10();
    logic [31:0] a, b;
    wr(8'h00, 32'd1);
    cpu_halted = 1'b1;
    @(negedge clk);
    rd(8'h10, a);
    repeat (10) @(negedge clk);
    rd(8'h10, b); check(a == b, "R10 paused", b, a);
    cpu_halted = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h10, b); check(b == a - 3, "R10 resumes", b, a - 3);
    wr(8'h00, 32'd0);
  endtask

  task automatic t_debug_R7();
    logic [31:0] v;
    bit seen = 0;
    wr(8'h40, 32'h00012345);
    rd(8'h40, v); check(v == 0, "R7 other value ignored", v, 0);
    wr(8'h40, KEY);
    rd(8'h40, v); check(v == 0, "R7 plain key ignored", v, 0);
    wr(8'h40, KEY ^ 32'h1);
    rd(8'h40, v); check(v == 1, "R7 disabled", v, 1);
    wr(8'h40, 32'd0);
    rd(8'h40, v); check(v == 1, "R7 sticky", v, 1);
    load(32'd2);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (rst_req) seen = 1;
    end
    check(!seen, "R7 no reset", seen, 0);
    rd(8'h0C, v); check(v == 1, "R7 pending still set", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R11();
    t_key_R1();
    t_lock_R2_R3_R4();
    t_period_R5_R6();
    t_irq_R8_R9();
    t_pause_R10();
    t_debug_R7();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule